// File: doc/BRIEF.md
# Bit Test-and-Modify Unit

This unit executes single-bit operations on a register operand. Each request names an operand, an operand width (16 or 32 bits), a bit index and one of four operations. The unit reports the original value of the addressed bit on a carry output and, for the three modifying operations, returns the operand with that bit complemented, cleared or set, together with a write-enable for the result.

The bit index comes either from an 8-bit immediate, which is zero-extended, or from a register value. Only the index modulo the operand width selects the bit; the quotient is discarded. In 16-bit mode the upper half of the operand passes through untouched. The result, carry, write-enable and a one-cycle done pulse appear one clock after the valid strobe. Between requests the result and carry outputs hold their last value.

Top module: `bittm_unit`

## Requirements
- R1: The operation code selects the action: 2'b00 test only, 2'b01 test then complement, 2'b10 test then clear to 0, 2'b11 test then set to 1.
- R2: For every operation, out_carry equals the addressed bit of the operand before any change.
- R3: The addressed bit is the index modulo the width: index bits [4:0] when in_wide=1 (32-bit) and bits [3:0] when in_wide=0 (16-bit). All higher index bits are ignored, including those that make the index negative.
- R4: With in_imm_sel=1 the index is in_imm zero-extended; with in_imm_sel=0 it is in_idx. The unused source has no effect.
- R5: The test-only operation returns the operand unchanged and keeps out_wen low.
- R6: In 16-bit mode the result bits [31:16] equal the input operand bits [31:16].
- R7: Result, carry, out_wen and out_done appear on the first clock edge after in_valid. out_done is high for one cycle per request. out_wen is high only together with out_done and only for the modifying operations.
- R8: After reset, out_done, out_wen, out_carry and out_opnd are all 0.
- R9: In a cycle without in_valid, out_opnd and out_carry keep their values, and out_done and out_wen are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation code (R1) |
| in_wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit |
| in_imm_sel | input | 1 | 1 = index from immediate |
| in_imm | input | 8 | Immediate bit index |
| in_idx | input | 32 | Register bit index |
| in_opnd | input | 32 | Operand |
| out_opnd | output | 32 | Updated operand |
| out_carry | output | 1 | Original value of the addressed bit |
| out_wen | output | 1 | Result write-enable |
| out_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that in_op, in_wide, in_opnd and the index inputs are known (not X) whenever in_valid is high, because they compare the registered outputs against the previous cycle's inputs. They also assume that in_valid stays low during reset. The bench changes inputs only on the falling clock edge, holds in_valid low throughout reset, and sets every field of each request to a defined value, including out-of-range and negative indices that exercise the modulo rule.

// File: rtl/bittm_pkg.sv
package bittm_pkg;
  localparam int FULL_W_DEF = 32;
  localparam int HALF_W_DEF = 16;
  localparam int IMM_W_DEF  = 8;

  typedef enum logic [1:0] {
    BOP_TEST = 2'b00,
    BOP_FLIP = 2'b01,
    BOP_CLR  = 2'b10,
    BOP_SET  = 2'b11
  } bop_e;
endpackage

// File: rtl/bittm_index.sv
module bittm_index #(
  parameter int FULL_W = bittm_pkg::FULL_W_DEF,
  parameter int HALF_W = bittm_pkg::HALF_W_DEF,
  parameter int IMM_W  = bittm_pkg::IMM_W_DEF,
  localparam int POS_W = $clog2(FULL_W)
) (
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  imm,
  input  logic [FULL_W-1:0] idx,
  input  logic              wide,
  output logic [POS_W-1:0]  pos
);
  localparam logic [FULL_W-1:0] MOD_FULL = FULL_W;
  localparam logic [FULL_W-1:0] MOD_HALF = HALF_W;

  // zero-extend the immediate to operand width (R4)
  function automatic logic [FULL_W-1:0] extend_imm(input logic [IMM_W-1:0] v);
    return {{(FULL_W-IMM_W){1'b0}}, v};
  endfunction

  // index modulo operand width; the quotient is thrown away (R3)
  function automatic logic [POS_W-1:0] reduce_pos(input logic [FULL_W-1:0] v,
                                                  input logic wide_m);
    logic [FULL_W-1:0] half_v;
    half_v = {{(FULL_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
    return wide_m ? POS_W'(v % MOD_FULL) : POS_W'(half_v % MOD_HALF);
  endfunction

  logic [FULL_W-1:0] src;
  assign src = imm_sel ? extend_imm(imm) : idx;
  assign pos = reduce_pos(src, wide);
endmodule

// File: rtl/bittm_alter.sv
module bittm_alter #(
  parameter int FULL_W = bittm_pkg::FULL_W_DEF,
  localparam int POS_W = $clog2(FULL_W)
) (
  input  logic [FULL_W-1:0] opnd,
  input  logic [POS_W-1:0]  pos,
  input  bittm_pkg::bop_e   op,
  output logic [FULL_W-1:0] result,
  output logic              orig_bit,
  output logic              writes
);
  import bittm_pkg::*;

  function automatic logic [FULL_W-1:0] apply_op(input logic [FULL_W-1:0] v,
                                                 input logic [POS_W-1:0] p,
                                                 input bop_e o);
    logic [FULL_W-1:0] mask;
    mask = {{(FULL_W-1){1'b0}}, 1'b1} << p;
    case (o)
      BOP_FLIP: return v ^ mask;
      BOP_CLR:  return v & ~mask;
      BOP_SET:  return v | mask;
      default:  return v;
    endcase
  endfunction

  assign orig_bit = opnd[pos];
  assign result   = apply_op(opnd, pos, op);
  assign writes   = (op != BOP_TEST);
endmodule

// File: rtl/bittm_unit.sv
module bittm_unit #(
  parameter int FULL_W = bittm_pkg::FULL_W_DEF,
  parameter int HALF_W = bittm_pkg::HALF_W_DEF,
  parameter int IMM_W  = bittm_pkg::IMM_W_DEF,
  localparam int POS_W = $clog2(FULL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic              in_wide,
  input  logic              in_imm_sel,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [FULL_W-1:0] in_idx,
  input  logic [FULL_W-1:0] in_opnd,
  output logic [FULL_W-1:0] out_opnd,
  output logic              out_carry,
  output logic              out_wen,
  output logic              out_done
);
  import bittm_pkg::*;

  // named internal events for the assertions
  logic [POS_W-1:0]  pos_w;
  logic [FULL_W-1:0] alt_res_w;
  logic              alt_orig_w;
  logic              alt_writes_w;
  bop_e              op_w;

  assign op_w = bop_e'(in_op);

  bittm_index #(.FULL_W(FULL_W), .HALF_W(HALF_W), .IMM_W(IMM_W)) index_i (
    .imm_sel (in_imm_sel),
    .imm     (in_imm),
    .idx     (in_idx),
    .wide    (in_wide),
    .pos     (pos_w)
  );

  bittm_alter #(.FULL_W(FULL_W)) alter_i (
    .opnd     (in_opnd),
    .pos      (pos_w),
    .op       (op_w),
    .result   (alt_res_w),
    .orig_bit (alt_orig_w),
    .writes   (alt_writes_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_opnd  <= '0;
      out_carry <= 1'b0;
      out_wen   <= 1'b0;
      out_done  <= 1'b0;
    end else begin
      out_done <= in_valid;
      out_wen  <= in_valid && alt_writes_w;
      if (in_valid) begin
        out_opnd  <= alt_res_w;
        out_carry <= alt_orig_w;
      end
    end
  end

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);  // R7
  AST_WEN_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> out_done);  // R7
  AST_CARRY_ORIGINAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_carry == $past(in_opnd[pos_w]));  // R2
  AST_TEST_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b00) |=> (out_opnd == $past(in_opnd)) && !out_wen);  // R5
  AST_HALF_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide) |=> out_opnd[FULL_W-1:HALF_W] == $past(in_opnd[FULL_W-1:HALF_W]));  // R6
  AST_ONE_BIT_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $countones(out_opnd ^ $past(in_opnd)) <= 1);  // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_opnd) && $stable(out_carry) && !out_done);  // R9
endmodule

// File: tb/bittm_unit_tb.sv
module bittm_unit_tb_top;
  typedef struct {
    logic [31:0] res;
    logic        carry;
    logic        wen;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic        in_wide = 1'b0;
  logic        in_imm_sel = 1'b0;
  logic [7:0]  in_imm = 8'h00;
  logic [31:0] in_idx = 32'h0;
  logic [31:0] in_opnd = 32'h0;
  logic [31:0] out_opnd;
  logic        out_carry, out_wen, out_done;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  bittm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_wide(in_wide), .in_imm_sel(in_imm_sel), .in_imm(in_imm),
    .in_idx(in_idx), .in_opnd(in_opnd), .out_opnd(out_opnd),
    .out_carry(out_carry), .out_wen(out_wen), .out_done(out_done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one request, expected item computed from the requirements
  task automatic send(input logic [1:0] op, input bit wide, input bit isel,
                      input logic [7:0] imm, input logic [31:0] idx,
                      input logic [31:0] opnd, input string tag);
    exp_t e;
    longint unsigned ival;
    int n, p;
    n = wide ? 32 : 16;
    ival = isel ? longint'(imm) : (wide ? longint'(idx) : longint'(idx[15:0]));
    p = int'(ival % longint'(n));
    e.carry = opnd[p];
    e.res = opnd;
    case (op)
      2'b01: e.res[p] = ~opnd[p];
      2'b10: e.res[p] = 1'b0;
      2'b11: e.res[p] = 1'b1;
      default: ;
    endcase
    e.wen = (op != 2'b00);
    e.tag = tag;
    @(negedge clk);
    sb.push_back(e);
    in_valid = 1'b1; in_op = op; in_wide = wide; in_imm_sel = isel;
    in_imm = imm; in_idx = idx; in_opnd = opnd;
    @(negedge clk);
    in_valid = 1'b0;
    in_idx = 32'hDEAD_BEEF; in_imm = 8'hA5; in_opnd = 32'h1234_5678;
  endtask

  // monitor: compares each completion with the head of the scoreboard
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && out_done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7 unexpected done", 32'(out_done), 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_opnd == e.res, {e.tag, " result"}, out_opnd, e.res);
          check(out_carry == e.carry, {e.tag, " carry R2"}, 32'(out_carry), 32'(e.carry));
          check(out_wen == e.wen, {e.tag, " wen R7"}, 32'(out_wen), 32'(e.wen));
        end
      end else if (rst_n) begin
        check(!out_wen, "R7 wen without done", 32'(out_wen), 32'h0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_opnd == 32'h0 && !out_carry && !out_wen && !out_done,
          "R8 reset state", {out_opnd[28:0], out_carry, out_wen, out_done}, 32'h0);
    rst_n = 1'b1;
    // R1: each operation on 32-bit operands
    send(2'b00, 1'b1, 1'b1, 8'd5,  32'h0, 32'h0000_0020, "R1 R5 test bit 5");
    send(2'b01, 1'b1, 1'b1, 8'd7,  32'h0, 32'h0000_0055, "R1 flip bit 7");
    send(2'b10, 1'b1, 1'b0, 8'h0,  32'd3, 32'hFFFF_FFFF, "R1 clear bit 3");
    send(2'b11, 1'b1, 1'b0, 8'h0,  32'd0, 32'h0000_0000, "R1 set bit 0");
    send(2'b11, 1'b1, 1'b0, 8'h0,  32'd0, 32'h0000_0001, "R2 set already set");
    // R3: modulo, quotient discarded, negative index
    send(2'b01, 1'b1, 1'b0, 8'h0,  32'd100, 32'h0, "R3 index 100 wide");
    send(2'b10, 1'b0, 1'b0, 8'h0,  32'd35, 32'h0000_FFFF, "R3 index 35 half");
    send(2'b11, 1'b1, 1'b0, 8'h0,  32'hFFFF_FFFF, 32'h0, "R3 negative wide");
    send(2'b11, 1'b0, 1'b0, 8'h0,  32'h7FFF_FFFF, 32'h0, "R3 negative half");
    // R4: immediate zero-extended, register index ignored
    send(2'b01, 1'b1, 1'b1, 8'd200, 32'd1, 32'h0, "R4 imm 200");
    send(2'b01, 1'b1, 1'b0, 8'd200, 32'd1, 32'h0, "R4 reg idx 1");
    // R5 test leaves operand unchanged
    send(2'b00, 1'b0, 1'b1, 8'd15, 32'h0, 32'hCAFE_8001, "R5 test half");
    // R6 upper half passes in 16-bit mode
    send(2'b01, 1'b0, 1'b0, 8'h0, 32'd31, 32'hA5A5_0000, "R6 flip half");
    send(2'b10, 1'b0, 1'b1, 8'd16, 32'h0, 32'hFFFF_FFFF, "R6 clear half");
    // R7 back-to-back requests
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b11; in_wide = 1'b1; in_imm_sel = 1'b1;
    in_imm = 8'd9; in_opnd = 32'h0;
    sb.push_back('{32'h0000_0200, 1'b0, 1'b1, "R7 b2b first"});
    @(negedge clk);
    in_op = 2'b00; in_imm = 8'd4; in_opnd = 32'h0000_0010;
    sb.push_back('{32'h0000_0010, 1'b1, 1'b0, "R7 b2b second"});
    @(negedge clk);
    in_valid = 1'b0; in_opnd = 32'hFFFF_FFFF;
    // R9 hold while idle
    repeat (4) @(negedge clk);
    check(out_opnd == 32'h0000_0010, "R9 result held", out_opnd, 32'h0000_0010);
    check(out_carry == 1'b1, "R9 carry held", 32'(out_carry), 32'h1);
    check(!out_done && !out_wen, "R9 idle no done", {out_done, out_wen}, 32'h0);
    check(sb.size() == 0, "R7 all results seen", sb.size(), 32'h0);
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!ended) begin
      ended = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule